// File: doc/BRIEF.md
# Carrier-Sense Transmit Access Sequencer

This block decides when a node on a shared serial bus may put a frame on the wire. A one-cycle start request carries a 16-bit backoff slot count. The sequencer first waits, for a bounded time, until the line-idle input shows a quiet bus. It then counts the backoff in fixed-length slots and gives up if the bus turns active during that time. When the count ends, it reads an externally latched "transition seen" flag as a last collision check. It cleared that latch when the backoff began.

If the bus is still free, the sequencer turns the line driver on and then off again while the line idles at ones. This short pulse arms the transition detectors of the other nodes. It then enables the transmitter and releases the frame to a downstream framer. When the framer reports that the closing check sequence has left, the transmitter is switched off. The driver is held on for a short tail and then released, and the receiver is enabled again.

A link-busy input skips the idle wait and the backoff altogether. A diagnostic mode keeps the driver and terminal-ready outputs low so that transmit data loops back locally. Each attempt ends with a done strobe and exactly one of three outcome pulses: sent, no-idle timeout, or bus busy.

Top module: `csma_tx_gate`

## Requirements
- R1: After reset, done_o, sent_o, no_idle_o, bus_busy_o, trans_clr_o, frame_go_o, drv_en_o, dtr_o and tx_en_o are low and rx_en_o is high. The sequencer is idle and accepts req_i.
- R2: If line_idle_i stays low after an accepted request, the attempt ends with no_idle_o after IDLE_TO_SLOTS slot times. done_o rises IDLE_TO_SLOTS*CLK_PER_SLOT+1 cycles after the request edge. The driver is never enabled.
- R3: Backoff is counted in slots of CLK_PER_SLOT cycles. With a slot count of n and no disturbance, drv_en_o first rises n*CLK_PER_SLOT+2 cycles after the cycle in which trans_clr_o is high. A count of 0 gives no slot wait.
- R4: If line_idle_i goes low during the backoff, the attempt ends with bus_busy_o, and neither the driver nor frame_go_o is activated.
- R5: trans_clr_o is high for exactly one cycle, when the backoff begins. A transition flag already set before that point therefore does not block the frame.
- R6: If trans_seen_i is high when the backoff count is exhausted, the attempt ends with bus_busy_o and no frame is released.
- R7: If link_busy_i is high with the request, drv_en_o rises in the cycle after the request edge. There is no trans_clr_o pulse, and line_idle_i and trans_seen_i are not consulted.
- R8: The pre-frame pulse holds drv_en_o high for PULSE_CYCLES cycles and then low for GAP_CYCLES cycles, with dtr_o high throughout. After that, drv_en_o and tx_en_o rise together, and frame_go_o is high for one cycle in that same cycle.
- R9: In the cycle after frame_end_i is sampled high, tx_en_o falls. drv_en_o stays high for TAIL_CYCLES more cycles and falls in the same cycle in which done_o and sent_o rise.
- R10: In normal mode, rx_en_o is low from the first cycle of the pulse until the cycle in which done_o rises, where it is high again.
- R11: In diagnostic mode (diag_i high with the request), drv_en_o and dtr_o stay low and rx_en_o stays high for the whole attempt. tx_en_o and frame_go_o still sequence the frame.
- R12: Every attempt produces exactly one one-cycle done_o pulse. The done_o cycle carries exactly one of sent_o, no_idle_o and bus_busy_o, and none of these three is high in any other cycle.
- R13: A request that arrives while an attempt is in progress is ignored, and no further attempt follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle start request |
| slots_i | input | SLOT_W | Backoff length in slots, sampled with the request |
| link_busy_i | input | 1 | Send immediately, skipping idle wait and backoff |
| diag_i | input | 1 | Local loopback mode, sampled with the request |
| line_idle_i | input | 1 | High while the bus is sensed idle |
| trans_seen_i | input | 1 | Latched flag: a line transition has been seen |
| frame_end_i | input | 1 | Framer pulse: closing check sequence has left |
| trans_clr_o | output | 1 | One-cycle clear for the transition latch |
| frame_go_o | output | 1 | One-cycle release of the frame to the framer |
| drv_en_o | output | 1 | Line driver enable |
| dtr_o | output | 1 | Terminal-ready output, low in diagnostic mode |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| done_o | output | 1 | Attempt finished |
| sent_o | output | 1 | Outcome: frame sent |
| no_idle_o | output | 1 | Outcome: bus never went idle |
| bus_busy_o | output | 1 | Outcome: activity during backoff or transition seen |

## Verification
The assertions assume that req_i is a single-cycle pulse. They also assume that frame_end_i is pulsed only after frame_go_o, and that trans_seen_i behaves as a latch cleared by trans_clr_o. The bench drives every input at the falling clock edge. It models the transition latch itself, sets it only before the request or a fixed number of cycles after the clear pulse, and returns frame_end_i four cycles after frame_go_o. Line activity is produced only as a delayed rise of line_idle_i, or as a drop a few cycles into the backoff, so each table row leads to exactly one expected outcome.

// File: rtl/csma_pkg.sv
package csma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_WAIT, ST_BACKOFF, ST_CHECK,
      ST_PULSE, ST_GAP, ST_SEND, ST_TAIL
   } seq_state_t;

   typedef enum logic [1:0] {
      FIN_NONE, FIN_SENT, FIN_NOIDLE, FIN_BUSY
   } fin_t;
endpackage

// File: rtl/csma_slot_ticker.sv
module csma_slot_ticker #(
   parameter int CLK_PER_SLOT = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   generate
      if (CLK_PER_SLOT == 1) begin : g_direct
         assign tick = 1'b1;
         logic unused_ins;
         assign unused_ins = ^{clk, rst_n, restart};
      end else begin : g_count
         localparam int CW = $clog2(CLK_PER_SLOT);
         localparam logic [CW-1:0] TOP = CW'(CLK_PER_SLOT - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt <= TOP;
            else if (restart || cnt == '0)  cnt <= TOP;
            else                            cnt <= cnt - 1'b1;
         end

         assign tick = (cnt == '0);

         // slot ticks never come back to back (R3)
         p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/csma_downcount.sv
module csma_downcount #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (load)  cnt <= load_val;
      else if (dec)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // the sequencer never decrements an exhausted count (R3)
   p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |-> !zero);
endmodule

// File: rtl/csma_tx_gate.sv
module csma_tx_gate
   import csma_pkg::*;
#(
   parameter int SLOT_W        = 16,
   parameter int CLK_PER_SLOT  = 20000,
   parameter int IDLE_TO_SLOTS = 5000,
   parameter int PULSE_CYCLES  = 75,
   parameter int GAP_CYCLES    = 80,
   parameter int TAIL_CYCLES   = 800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [SLOT_W-1:0] slots_i,
   input  logic              link_busy_i,
   input  logic              diag_i,
   input  logic              line_idle_i,
   input  logic              trans_seen_i,
   input  logic              frame_end_i,
   output logic              trans_clr_o,
   output logic              frame_go_o,
   output logic              drv_en_o,
   output logic              dtr_o,
   output logic              tx_en_o,
   output logic              rx_en_o,
   output logic              done_o,
   output logic              sent_o,
   output logic              no_idle_o,
   output logic              bus_busy_o
);
   localparam int PH_MAX = (PULSE_CYCLES > GAP_CYCLES)
                           ? ((PULSE_CYCLES > TAIL_CYCLES) ? PULSE_CYCLES : TAIL_CYCLES)
                           : ((GAP_CYCLES > TAIL_CYCLES) ? GAP_CYCLES : TAIL_CYCLES);
   localparam int PH_W = $clog2(PH_MAX + 1);
   localparam logic [PH_W-1:0]   PULSE_M1 = PH_W'(PULSE_CYCLES - 1);
   localparam logic [PH_W-1:0]   GAP_M1   = PH_W'(GAP_CYCLES - 1);
   localparam logic [PH_W-1:0]   TAIL_M1  = PH_W'(TAIL_CYCLES - 1);
   localparam logic [SLOT_W-1:0] IDLE_TO  = SLOT_W'(IDLE_TO_SLOTS);

   // elaboration-time parameter checks
   if (CLK_PER_SLOT < 1) begin : g_bad_slot
      $error("CLK_PER_SLOT must be at least 1");
   end
   if (IDLE_TO_SLOTS < 1 || IDLE_TO_SLOTS >= (2 ** SLOT_W)) begin : g_bad_to
      $error("IDLE_TO_SLOTS must fit the slot counter");
   end
   if (PULSE_CYCLES < 1 || GAP_CYCLES < 1 || TAIL_CYCLES < 1) begin : g_bad_phase
      $error("phase lengths must be at least one cycle");
   end

   seq_state_t        state, nxt;
   fin_t              fin;
   logic              diag_q;
   logic [SLOT_W-1:0] slots_q;
   logic              tick, restart;
   logic              slot_load, slot_dec, slot_zero;
   logic [SLOT_W-1:0] slot_val;
   logic              ph_load, ph_dec, ph_zero;
   logic [PH_W-1:0]   ph_val;
   logic              clr_n, go_n;
   logic              tx_phase;

   csma_slot_ticker #(.CLK_PER_SLOT(CLK_PER_SLOT)) u_ticker (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick));

   csma_downcount #(.W(SLOT_W)) u_slots (
      .clk(clk), .rst_n(rst_n), .load(slot_load), .load_val(slot_val),
      .dec(slot_dec), .zero(slot_zero));

   csma_downcount #(.W(PH_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val),
      .dec(ph_dec), .zero(ph_zero));

   always_comb begin
      nxt       = state;
      fin       = FIN_NONE;
      restart   = 1'b0;
      slot_load = 1'b0;
      slot_val  = slots_q;
      slot_dec  = 1'b0;
      ph_load   = 1'b0;
      ph_val    = PULSE_M1;
      ph_dec    = 1'b0;
      clr_n     = 1'b0;
      go_n      = 1'b0;
      unique case (state)
         ST_IDLE: if (req_i) begin
            if (link_busy_i) begin
               nxt     = ST_PULSE;
               ph_load = 1'b1;
            end else begin
               nxt       = ST_WAIT;
               slot_load = 1'b1;
               slot_val  = IDLE_TO;
               restart   = 1'b1;
            end
         end
         ST_WAIT: begin
            if (line_idle_i) begin
               nxt       = ST_BACKOFF;
               slot_load = 1'b1;
               restart   = 1'b1;
               clr_n     = 1'b1;
            end else if (slot_zero) begin
               nxt = ST_IDLE;
               fin = FIN_NOIDLE;
            end else begin
               slot_dec = tick;
            end
         end
         ST_BACKOFF: begin
            if (!line_idle_i) begin
               nxt = ST_IDLE;
               fin = FIN_BUSY;
            end else if (slot_zero) begin
               nxt = ST_CHECK;
            end else begin
               slot_dec = tick;
            end
         end
         ST_CHECK: begin
            if (trans_seen_i) begin
               nxt = ST_IDLE;
               fin = FIN_BUSY;
            end else begin
               nxt     = ST_PULSE;
               ph_load = 1'b1;
            end
         end
         ST_PULSE: begin
            if (ph_zero) begin
               nxt     = ST_GAP;
               ph_load = 1'b1;
               ph_val  = GAP_M1;
            end else ph_dec = 1'b1;
         end
         ST_GAP: begin
            if (ph_zero) begin
               nxt  = ST_SEND;
               go_n = 1'b1;
            end else ph_dec = 1'b1;
         end
         ST_SEND: if (frame_end_i) begin
            nxt     = ST_TAIL;
            ph_load = 1'b1;
            ph_val  = TAIL_M1;
         end
         ST_TAIL: begin
            if (ph_zero) begin
               nxt = ST_IDLE;
               fin = FIN_SENT;
            end else ph_dec = 1'b1;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         diag_q      <= 1'b0;
         slots_q     <= '0;
         trans_clr_o <= 1'b0;
         frame_go_o  <= 1'b0;
         done_o      <= 1'b0;
         sent_o      <= 1'b0;
         no_idle_o   <= 1'b0;
         bus_busy_o  <= 1'b0;
      end else begin
         state       <= nxt;
         if (state == ST_IDLE && req_i) begin
            diag_q  <= diag_i;
            slots_q <= slots_i;
         end
         trans_clr_o <= clr_n;
         frame_go_o  <= go_n;
         done_o      <= (fin != FIN_NONE);
         sent_o      <= (fin == FIN_SENT);
         no_idle_o   <= (fin == FIN_NOIDLE);
         bus_busy_o  <= (fin == FIN_BUSY);
      end
   end

   assign tx_phase = (state == ST_PULSE) || (state == ST_GAP) ||
                     (state == ST_SEND)  || (state == ST_TAIL);
   assign drv_en_o = !diag_q && ((state == ST_PULSE) || (state == ST_SEND) ||
                                 (state == ST_TAIL));
   assign dtr_o    = !diag_q && tx_phase;
   assign tx_en_o  = (state == ST_SEND);
   assign rx_en_o  = diag_q || !tx_phase;

   // ---------------------------------------------------------------- checks
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (!tx_en_o && !drv_en_o && rx_en_o));

   p_noidle_from_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      no_idle_o |-> ($past(state) == ST_WAIT && !$past(drv_en_o)));

   p_busy_undriven_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_busy_o |-> !$past(drv_en_o));

   p_clr_enters_backoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trans_clr_o |-> (state == ST_BACKOFF));

   p_clr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trans_clr_o |=> !trans_clr_o);

   p_go_with_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_go_o |-> (tx_en_o && $past(state) == ST_GAP));

   p_go_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_go_o |=> !frame_go_o);

   p_sent_from_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sent_o |-> ($past(state) == ST_TAIL && !drv_en_o));

   p_outcome_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sent_o, no_idle_o, bus_busy_o}));

   p_done_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o == ($countones({sent_o, no_idle_o, bus_busy_o}) == 1));

   p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: tb/csma_tx_gate_bench.sv
module csma_tx_gate_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CPS   = 4;
   localparam int TO    = 10;
   localparam int PULSE = 3;
   localparam int GAP   = 2;
   localparam int TAIL  = 5;

   localparam logic [1:0] O_SENT = 2'd1, O_NOIDLE = 2'd2, O_BUSY = 2'd3;

   typedef struct packed {
      logic        lb;
      logic        dg;
      logic [15:0] slots;
      logic [7:0]  idle_dly;   // 255: never idle
      logic        drop;
      logic [1:0]  trans;      // 0 none, 1 stale, 2 during backoff
      logic        mid;
      logic [1:0]  exp_out;
   } case_t;

   localparam int NCASE = 10;
   localparam case_t CASES [NCASE] = '{
      '{1'b0, 1'b0, 16'd2, 8'd0,   1'b0, 2'd0, 1'b0, O_SENT},
      '{1'b0, 1'b0, 16'd0, 8'd5,   1'b0, 2'd0, 1'b0, O_SENT},
      '{1'b0, 1'b0, 16'd3, 8'd0,   1'b1, 2'd0, 1'b0, O_BUSY},
      '{1'b0, 1'b0, 16'd2, 8'd0,   1'b0, 2'd2, 1'b0, O_BUSY},
      '{1'b0, 1'b0, 16'd1, 8'd0,   1'b0, 2'd1, 1'b0, O_SENT},
      '{1'b0, 1'b0, 16'd2, 8'd255, 1'b0, 2'd0, 1'b0, O_NOIDLE},
      '{1'b1, 1'b0, 16'd5, 8'd255, 1'b0, 2'd1, 1'b0, O_SENT},
      '{1'b0, 1'b1, 16'd1, 8'd0,   1'b0, 2'd0, 1'b0, O_SENT},
      '{1'b0, 1'b0, 16'd4, 8'd3,   1'b0, 2'd0, 1'b1, O_SENT},
      '{1'b1, 1'b1, 16'd0, 8'd255, 1'b0, 2'd0, 1'b1, O_SENT}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req = 1'b0, lb = 1'b0, dg = 1'b0, line_idle = 1'b1;
   logic set_trans = 1'b0, trans_latch, frame_end = 1'b0;
   logic [15:0] slots = '0;
   logic trans_clr, frame_go, drv_en, dtr, tx_en, rx_en;
   logic done, sent, no_idle, bus_busy;
   int n_run = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         trans_latch <= 1'b0;
      else if (trans_clr) trans_latch <= 1'b0;
      else if (set_trans) trans_latch <= 1'b1;
   end

   csma_tx_gate #(
      .SLOT_W(16), .CLK_PER_SLOT(CPS), .IDLE_TO_SLOTS(TO),
      .PULSE_CYCLES(PULSE), .GAP_CYCLES(GAP), .TAIL_CYCLES(TAIL)
   ) u_csma_tx_gate (
      .clk(clk), .rst_n(rst_n), .req_i(req), .slots_i(slots),
      .link_busy_i(lb), .diag_i(dg), .line_idle_i(line_idle),
      .trans_seen_i(trans_latch), .frame_end_i(frame_end),
      .trans_clr_o(trans_clr), .frame_go_o(frame_go), .drv_en_o(drv_en),
      .dtr_o(dtr), .tx_en_o(tx_en), .rx_en_o(rx_en), .done_o(done),
      .sent_o(sent), .no_idle_o(no_idle), .bus_busy_o(bus_busy));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_case(input case_t c, input int idx);
      int k = 0, clr_cyc = -1, clr_cnt = 0, go_cyc = -1, go_cnt = 0;
      int r1 = -1, f1 = -1, r2 = -1, tf = -1, df2 = -1, done_k = -1;
      int pulses = 0, drv_seen = 0, dtr_seen = 0, rx_low = 0;
      bit prev_drv = 1'b0, prev_tx = 1'b0, dtr_r1 = 1'b0, rx_r1 = 1'b1;
      bit rx_done = 1'b0, pulse_at_done = 1'b0;
      logic [1:0] act = 2'd0;
      int late = 0;
      @(negedge clk);
      slots = c.slots; lb = c.lb; dg = c.dg;
      line_idle = (c.idle_dly == 8'd0);
      set_trans = (c.trans == 2'd1);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0; set_trans = 1'b0;
      while (done_k < 0 && k < 4000) begin
         if (drv_en && r1 < 0) begin r1 = k; dtr_r1 = dtr; rx_r1 = rx_en; end
         else if (!drv_en && r1 >= 0 && f1 < 0) f1 = k;
         else if (drv_en && f1 >= 0 && r2 < 0) r2 = k;
         if (prev_tx && !tx_en && tf < 0) tf = k;
         if (prev_drv && !drv_en && r2 >= 0 && df2 < 0) df2 = k;
         prev_drv = drv_en; prev_tx = tx_en;
         if (drv_en) drv_seen++;
         if (dtr) dtr_seen++;
         if (!rx_en) rx_low++;
         if (trans_clr) begin clr_cnt++; if (clr_cyc < 0) clr_cyc = k; end
         if (frame_go) begin go_cnt++; go_cyc = k; end
         pulses += int'(sent) + int'(no_idle) + int'(bus_busy);
         if (done) begin
            done_k = k; rx_done = rx_en;
            pulse_at_done = (int'(sent) + int'(no_idle) + int'(bus_busy)) == 1;
            act = sent ? O_SENT : no_idle ? O_NOIDLE : bus_busy ? O_BUSY : 2'd0;
         end
         line_idle = (c.idle_dly != 8'd255) && (k + 1 >= int'(c.idle_dly)) &&
                     !(c.drop && clr_cyc >= 0 && k >= clr_cyc + 3);
         set_trans = (c.trans == 2'd2) && clr_cyc >= 0 && k == clr_cyc + 2;
         frame_end = go_cyc >= 0 && k == go_cyc + 4;
         req = c.mid && k == 3;
         @(negedge clk);
         k++;
      end
      line_idle = 1'b1; frame_end = 1'b0; req = 1'b0; set_trans = 1'b0;

      // outcome per case
      if (c.exp_out == O_NOIDLE)
         check(act == c.exp_out, $sformatf("R2 case %0d outcome", idx), act, c.exp_out);
      else if (c.drop)
         check(act == c.exp_out, $sformatf("R4 case %0d outcome", idx), act, c.exp_out);
      else if (c.trans == 2'd2)
         check(act == c.exp_out, $sformatf("R6 case %0d outcome", idx), act, c.exp_out);
      else if (c.trans == 2'd1 && !c.lb)
         check(act == c.exp_out, $sformatf("R5 stale flag case %0d outcome", idx), act, c.exp_out);
      else
         check(act == c.exp_out, $sformatf("R8 case %0d outcome", idx), act, c.exp_out);

      check(pulses == 1 && pulse_at_done, $sformatf("R12 case %0d single outcome pulse", idx), pulses, 1);

      if (c.exp_out == O_NOIDLE) begin
         check(done_k == TO*CPS + 1, $sformatf("R2 case %0d timeout latency", idx), done_k, TO*CPS + 1);
         check(drv_seen == 0, $sformatf("R2 case %0d driver quiet", idx), drv_seen, 0);
      end
      if (c.exp_out == O_BUSY)
         check(drv_seen == 0 && go_cnt == 0, $sformatf("R4 R6 case %0d no drive", idx), drv_seen + go_cnt, 0);
      if (!c.lb && c.exp_out != O_NOIDLE)
         check(clr_cnt == 1, $sformatf("R5 case %0d clear pulses", idx), clr_cnt, 1);
      if (!c.lb && !c.dg && c.exp_out == O_SENT)
         check(r1 - clr_cyc == int'(c.slots)*CPS + 2, $sformatf("R3 case %0d backoff length", idx),
               r1 - clr_cyc, int'(c.slots)*CPS + 2);
      if (c.lb) begin
         check(clr_cnt == 0, $sformatf("R7 case %0d no clear", idx), clr_cnt, 0);
         if (!c.dg) check(r1 == 0, $sformatf("R7 case %0d immediate pulse", idx), r1, 0);
      end
      if (c.exp_out == O_SENT && !c.dg) begin
         check(f1 - r1 == PULSE, $sformatf("R8 case %0d pulse width", idx), f1 - r1, PULSE);
         check(r2 - f1 == GAP, $sformatf("R8 case %0d gap width", idx), r2 - f1, GAP);
         check(go_cyc == r2 && go_cnt == 1, $sformatf("R8 case %0d frame release", idx), go_cyc, r2);
         check(dtr_r1, $sformatf("R8 case %0d dtr during pulse", idx), dtr_r1, 1);
         check(df2 - tf == TAIL, $sformatf("R9 case %0d tail length", idx), df2 - tf, TAIL);
         check(done_k == df2, $sformatf("R9 case %0d done with driver off", idx), done_k, df2);
         check(!rx_r1 && rx_done, $sformatf("R10 case %0d receiver gating", idx), rx_done, 1);
      end
      if (c.dg) begin
         check(drv_seen == 0 && dtr_seen == 0, $sformatf("R11 case %0d lines low", idx), drv_seen + dtr_seen, 0);
         check(rx_low == 0, $sformatf("R11 case %0d receiver kept on", idx), rx_low, 0);
         check(go_cnt == 1 && tf >= 0, $sformatf("R11 case %0d frame sequenced", idx), go_cnt, 1);
      end
      if (c.mid) begin
         for (int j = 0; j < 60; j++) begin
            @(negedge clk);
            if (done || drv_en || trans_clr || tx_en) late++;
         end
         check(late == 0, $sformatf("R13 case %0d late request ignored", idx), late, 0);
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!done && !sent && !no_idle && !bus_busy, "R1 outcome strobes low", done, 0);
      check(!trans_clr && !frame_go && !drv_en && !dtr && !tx_en, "R1 controls low",
            int'(drv_en) + int'(tx_en) + int'(dtr), 0);
      check(rx_en, "R1 receiver enabled", rx_en, 1);

      for (int i = 0; i < NCASE; i++) run_case(CASES[i], i);

      // reset during an attempt returns to the idle state (R1)
      @(negedge clk);
      lb = 1'b1; dg = 1'b0; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!drv_en && !tx_en && rx_en && !done, "R1 reset mid-attempt", drv_en, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule